// File: doc/BRIEF.md
# Received-Word Packet Grouper

This block sits behind a serial receiver and collects the data words it delivers, each marked by a valid strobe, into packets. A packet closes on whichever of two end conditions occurs first: the arriving word equals a programmed delimiter, or the number of buffered words reaches a programmed length limit. Each condition has its own enable bit next to its value. With both enables low the grouper stays idle: words are dropped and no packet is ever formed.

The words of the packet being assembled are kept in a small local buffer. When a packet closes, the block raises a single-cycle done strobe together with the packet length, the cause of the close and the cycle stamp at which the packet's first word arrived. A read address port then gives access to the stored words in arrival order. If a packet fills the buffer before either end condition is met, the packet is forced closed and marked as overflowed.

Top module: `packet_grouper`

## Requirements
- R1: After reset, `pkt_done`, `pkt_ovf`, `pkt_by_delim` and `pkt_by_limit` are 0 and `pkt_len` is 0.
- R2: With `cfg_delim_en` = 1, an accepted word equal to `cfg_delim` closes the packet; that word is stored as the last word and is counted in `pkt_len`, and `pkt_by_delim` is 1.
- R3: With `cfg_limit_en` = 1, the packet closes on the accepted word that brings the stored count to `cfg_limit` (legal values 1 to DEPTH); `pkt_len` then equals `cfg_limit` and `pkt_by_limit` is 1.
- R4: The packet closes at the first word meeting either enabled condition; when one word meets both, both `pkt_by_delim` and `pkt_by_limit` are 1.
- R5: A condition whose enable bit is 0 never closes a packet; with both enables 0, accepted words are discarded, `pkt_done` stays 0 and no word is kept toward a later packet.
- R6: When the DEPTH-th word of a packet meets no enabled condition, the packet closes with `pkt_ovf` = 1 and `pkt_len` = DEPTH; `pkt_ovf` is 0 for every other close.
- R7: `pkt_done` is high for exactly one clock, in the cycle after the edge that accepted the closing word.
- R8: `pkt_ts` gives the value of a free-running cycle count (0 in the first cycle after reset, +1 per clock) at the edge that accepted the packet's first word.
- R9: After a close the buffer is empty: the next accepted word is stored at address 0 and the next packet's length counts from 1.
- R10: After a close, `rd_word` at `rd_addr` k (0 to `pkt_len`-1) returns the k-th word of the packet in arrival order, and keeps returning it while no new word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word strobe from the receiver |
| in_word | input | WORD_W | Received word |
| cfg_delim_en | input | 1 | Enable the delimiter end condition |
| cfg_delim | input | WORD_W | Delimiter value |
| cfg_limit_en | input | 1 | Enable the length end condition |
| cfg_limit | input | CNT_W | Word count that closes a packet |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_word | output | WORD_W | Stored word at `rd_addr` |
| pkt_done | output | 1 | One-cycle packet close strobe |
| pkt_len | output | CNT_W | Length of the last closed packet |
| pkt_by_delim | output | 1 | Last packet closed by delimiter |
| pkt_by_limit | output | 1 | Last packet closed by length limit |
| pkt_ovf | output | 1 | Last packet closed by buffer overflow |
| pkt_ts | output | TS_W | Cycle stamp of the last packet's first word |

## Verification
The grouper is driven with delimiter-only traffic, limit-only traffic, traffic where the delimiter arrives before, and exactly at, the limit position, and with no condition enabled. Delimiter-only runs show that the delimiter is kept as the packet's last word, and limit-only runs containing the delimiter value show that a disabled condition is inert. The coincident case separates an either-first rule from a priority rule, and a run of DEPTH unmatched words separates a forced overflow close from a normal one. Back-to-back packets and a disabled-then-enabled sequence show that the buffer restarts empty and that discarded words leave no trace.

// File: rtl/pg_pkg.sv
package pg_pkg;

    // Why a packet was closed; more than one bit may be set.
    typedef struct packed {
        logic delim;
        logic limit;
        logic ovf;
    } close_cause_t;

    // Combine the three end tests of one accepted word.
    function automatic close_cause_t classify(input logic hit_delim,
                                              input logic hit_limit,
                                              input logic at_full);
        close_cause_t c;
        c.delim = hit_delim;
        c.limit = hit_limit;
        c.ovf   = at_full && !hit_delim && !hit_limit;
        return c;
    endfunction

    function automatic logic closes(input close_cause_t c);
        return c.delim || c.limit || c.ovf;
    endfunction

endpackage

// File: rtl/pg_tick.sv
module pg_tick #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] tick
);
    always_ff @(posedge clk) begin
        if (rst) tick <= '0;
        else     tick <= tick + 1'b1;
    end
endmodule

// File: rtl/pg_store.sv
module pg_store #(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 8,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < DEPTH) rd_data = slots[rd_addr];
    end
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
    import pg_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 8,
    parameter int TS_W   = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cfg_delim_en,
    input  logic [WORD_W-1:0] cfg_delim,
    input  logic              cfg_limit_en,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic [TS_W-1:0]   tick,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              pkt_done,
    output logic [CNT_W-1:0]  pkt_len,
    output close_cause_t      pkt_cause,
    output logic [TS_W-1:0]   pkt_ts
);
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] fill_nx;
    logic [TS_W-1:0]  first_ts_q;
    logic [TS_W-1:0]  first_ts;
    logic             grouping;
    logic             take;
    close_cause_t     cause;

    assign grouping = cfg_delim_en || cfg_limit_en;
    assign take     = in_valid && grouping;
    assign fill_nx  = fill_q + 1'b1;
    assign first_ts = (fill_q == '0) ? tick : first_ts_q;

    // Word is appended first; the end tests see the count including it.
    assign cause = classify(cfg_delim_en && (in_word == cfg_delim),
                            cfg_limit_en && (fill_nx == cfg_limit),
                            fill_nx == CNT_W'(DEPTH));

    assign wr_en   = take;
    assign wr_addr = fill_q[ADDR_W-1:0];
    assign wr_data = in_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q     <= '0;
            first_ts_q <= '0;
            pkt_done   <= 1'b0;
            pkt_len    <= '0;
            pkt_cause  <= '0;
            pkt_ts     <= '0;
        end else begin
            pkt_done <= 1'b0;
            if (take) begin
                first_ts_q <= first_ts;
                if (closes(cause)) begin
                    fill_q    <= '0;
                    pkt_done  <= 1'b1;
                    pkt_len   <= fill_nx;
                    pkt_cause <= cause;
                    pkt_ts    <= first_ts;
                end else begin
                    fill_q <= fill_nx;
                end
            end
        end
    end

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
        int'(fill_q) < DEPTH);

    p_done_after_word_r7: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> $past(in_valid));

    p_done_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> $past(cfg_delim_en || cfg_limit_en));

    p_len_range_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_len != '0) && (int'(pkt_len) <= DEPTH));

    p_ovf_full_r6: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && pkt_cause.ovf) |-> (int'(pkt_len) == DEPTH));

    p_limit_len_r3: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && pkt_cause.limit) |-> (pkt_len == $past(cfg_limit)));

    p_delim_last_r2: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && pkt_cause.delim) |-> ($past(in_word) == $past(cfg_delim)));

    p_ovf_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> $onehot0({pkt_cause.ovf, pkt_cause.delim || pkt_cause.limit}));
endmodule

// File: rtl/packet_grouper.sv
module packet_grouper
    import pg_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 8,
    parameter int TS_W   = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cfg_delim_en,
    input  logic [WORD_W-1:0] cfg_delim,
    input  logic              cfg_limit_en,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic              pkt_done,
    output logic [CNT_W-1:0]  pkt_len,
    output logic              pkt_by_delim,
    output logic              pkt_by_limit,
    output logic              pkt_ovf,
    output logic [TS_W-1:0]   pkt_ts
);
    logic [TS_W-1:0]   tick;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    close_cause_t      cause;

    pg_tick #(.TS_W(TS_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pg_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .TS_W(TS_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .cfg_delim_en (cfg_delim_en),
        .cfg_delim    (cfg_delim),
        .cfg_limit_en (cfg_limit_en),
        .cfg_limit    (cfg_limit),
        .tick         (tick),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pkt_done     (pkt_done),
        .pkt_len      (pkt_len),
        .pkt_cause    (cause),
        .pkt_ts       (pkt_ts)
    );

    pg_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    assign pkt_by_delim = cause.delim;
    assign pkt_by_limit = cause.limit;
    assign pkt_ovf      = cause.ovf;
endmodule

// File: tb/packet_grouper_bench.sv
module packet_grouper_bench;
    localparam int WORD_W = 9;
    localparam int DEPTH  = 8;
    localparam int TS_W   = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [WORD_W-1:0] in_word = '0;
    logic              cfg_delim_en = 1'b0;
    logic [WORD_W-1:0] cfg_delim = '0;
    logic              cfg_limit_en = 1'b0;
    logic [CNT_W-1:0]  cfg_limit = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [WORD_W-1:0] rd_word;
    logic              pkt_done;
    logic [CNT_W-1:0]  pkt_len;
    logic              pkt_by_delim, pkt_by_limit, pkt_ovf;
    logic [TS_W-1:0]   pkt_ts;

    int checks = 0;
    int errors = 0;
    int tb_tick = 0;
    int first_stamp = 0;
    logic last_done;

    packet_grouper #(.WORD_W(WORD_W), .DEPTH(DEPTH), .TS_W(TS_W)) u_packet_grouper (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .cfg_delim_en(cfg_delim_en), .cfg_delim(cfg_delim),
        .cfg_limit_en(cfg_limit_en), .cfg_limit(cfg_limit),
        .rd_addr(rd_addr), .rd_word(rd_word), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .pkt_by_delim(pkt_by_delim),
        .pkt_by_limit(pkt_by_limit), .pkt_ovf(pkt_ovf), .pkt_ts(pkt_ts)
    );

    always #5 clk = ~clk;

    // Independent cycle count, mirrors the stamp rule of R8.
    always @(posedge clk) begin
        if (rst) tb_tick <= 0;
        else     tb_tick <= tb_tick + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one word for one edge; afterwards outputs are sampled.
    task automatic send(input int w, input bit note_stamp);
        @(negedge clk);
        if (note_stamp) first_stamp = tb_tick;
        in_valid = 1'b1;
        in_word  = WORD_W'(w);
        @(negedge clk);
        in_valid  = 1'b0;
        last_done = pkt_done;
    endtask

    task automatic read_check(input string req, input int addr, input int exp);
        rd_addr = ADDR_W'(addr);
        #1;
        check(req, int'(rd_word), exp);
    endtask

    task automatic t_reset();
        check("R1 done", int'(pkt_done), 0);
        check("R1 len", int'(pkt_len), 0);
        check("R1 ovf", int'(pkt_ovf), 0);
        check("R1 causes", int'({pkt_by_delim, pkt_by_limit}), 0);
    endtask

    task automatic t_delim();
        cfg_delim_en = 1'b1; cfg_delim = 9'h00A; cfg_limit_en = 1'b0;
        send(9'h011, 1'b1);
        check("R2 no early close", int'(last_done), 0);
        send(9'h1A2, 1'b0);
        check("R2 no early close", int'(last_done), 0);
        send(9'h00A, 1'b0);
        check("R2 done on delim", int'(last_done), 1);
        check("R2 len includes delim", int'(pkt_len), 3);
        check("R2 cause delim", int'(pkt_by_delim), 1);
        check("R6 no ovf", int'(pkt_ovf), 0);
        check("R8 stamp", int'(pkt_ts), first_stamp);
        @(negedge clk);
        check("R7 one cycle", int'(pkt_done), 0);
        repeat (3) @(negedge clk);
        read_check("R10 word0", 0, 9'h011);
        read_check("R10 word1", 1, 9'h1A2);
        read_check("R2 delim last", 2, 9'h00A);
    endtask

    task automatic t_limit();
        cfg_delim_en = 1'b0; cfg_delim = 9'h00A;
        cfg_limit_en = 1'b1; cfg_limit = CNT_W'(4);
        send(9'h00A, 1'b1);
        check("R5 disabled delim inert", int'(last_done), 0);
        send(9'h021, 1'b0);
        send(9'h00A, 1'b0);
        check("R5 disabled delim inert", int'(last_done), 0);
        send(9'h033, 1'b0);
        check("R3 done at limit", int'(last_done), 1);
        check("R3 len", int'(pkt_len), 4);
        check("R3 cause", int'({pkt_by_delim, pkt_by_limit}), 1);
        read_check("R9 starts at 0", 0, 9'h00A);
        read_check("R10 word3", 3, 9'h033);
    endtask

    task automatic t_first();
        cfg_delim_en = 1'b1; cfg_delim = 9'h00A;
        cfg_limit_en = 1'b1; cfg_limit = CNT_W'(5);
        send(9'h001, 1'b1);
        send(9'h00A, 1'b0);
        check("R4 delim before limit", int'(last_done), 1);
        check("R4 len", int'(pkt_len), 2);
        check("R4 cause", int'({pkt_by_delim, pkt_by_limit}), 2);
        for (int i = 0; i < 4; i++) send(9'h040 + i, i == 0);
        check("R9 fresh count", int'(last_done), 0);
        send(9'h00A, 1'b0);
        check("R4 coincident close", int'(last_done), 1);
        check("R4 both causes", int'({pkt_by_delim, pkt_by_limit}), 3);
        check("R9 len from 1", int'(pkt_len), 5);
        check("R8 second stamp", int'(pkt_ts), first_stamp);
        read_check("R9 word0 new", 0, 9'h040);
    endtask

    task automatic t_overflow();
        cfg_delim_en = 1'b1; cfg_delim = 9'h1FF; cfg_limit_en = 1'b0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            send(9'h080 + i, i == 0);
            check("R6 no close before full", int'(last_done), 0);
        end
        send(9'h0F0, 1'b0);
        check("R6 forced close", int'(last_done), 1);
        check("R6 ovf flag", int'(pkt_ovf), 1);
        check("R6 len depth", int'(pkt_len), DEPTH);
        read_check("R10 last slot", DEPTH - 1, 9'h0F0);
        send(9'h1FF, 1'b0);
        check("R6 ovf clears", int'(pkt_ovf), 0);
        check("R9 single word packet", int'(pkt_len), 1);
    endtask

    task automatic t_off();
        cfg_delim_en = 1'b0; cfg_limit_en = 1'b0; cfg_limit = CNT_W'(2);
        for (int i = 0; i < 10; i++) begin
            send(9'h100 + i, 1'b0);
            check("R5 no packets when off", int'(last_done), 0);
        end
        cfg_limit_en = 1'b1;
        send(9'h0AA, 1'b1);
        check("R5 discarded words not kept", int'(last_done), 0);
        send(9'h0BB, 1'b0);
        check("R5 close after enable", int'(last_done), 1);
        check("R5 len only new words", int'(pkt_len), 2);
        read_check("R5 word0 new", 0, 9'h0AA);
        check("R8 stamp after off", int'(pkt_ts), first_stamp);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_delim();
                t_limit();
                t_first();
                t_overflow();
                t_off();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule